// File: doc/BRIEF.md
# Splittable Timer Channel

This block is one timer channel that counts down, either as a single 16-bit counter or, where the channel is built to allow it, as two 8-bit counters that run on their own. Two pulse vectors start and stop the counting. Each has one bit for the lower (or whole) half and one bit for the upper half. The block reports which halves are running on a two-bit enable status. A small register write port sets the function of the lower half (interval, square wave, event counting, one-shot delay or PWM), the compare and duty values, the split request and the timer output controls.

Each time a half's count passes zero, that half raises a one-cycle interrupt. The output pin shows a software-written level while timer output is off. While timer output is on, the pin shows the level that the count operation produces, and software writes to the level bit are thrown away.

Register map (address on `wr_addr`, data on `wr_data`): 0 = output enable (bit 0), 1 = software output level (bit 0), 2 = mode (bits 2:0 function, where 0 is interval, 1 is square wave, 2 is event counter, 3 is delay one-shot and 4 is PWM; bit 3 is the split request), 3/4 = compare low/high byte, 5/6 = duty low/high byte. In both vectors, bit 0 of `start_req`/`stop_req` addresses the lower or whole half and bit 1 addresses the upper half. In the interrupt vector, bit 0 of `irq` is the lower or whole half and bit 1 is the upper half.

Top module: `split_timer_chan`

## Requirements
- R1: A 1 on a bit of `start_req` (with the matching `stop_req` bit at 0) sets that half's `en_stat` bit after the clock edge and loads its counter from the compare value. A 0 bit leaves the other half untouched.
- R2: A 1 on a bit of `stop_req` clears that half's `en_stat` bit after the edge and freezes its count and output level.
- R3: When the start and stop bits of the same half are both 1 in one cycle, the stop takes effect and the half stays or becomes stopped.
- R4: After reset, `en_stat` is 00, `irq` is 00, output enable is off and the pin is 0.
- R5: A split request takes effect only when the parameter SPLIT_OK is 1. While the channel is not split, `start_req[1]` is ignored and `en_stat[1]` stays 0.
- R6: While output enable is 1, writes to the software level are discarded and the pin follows the timer level. While output enable is 0, the pin shows the software level.
- R7: In interval mode (function 0), a running counter with compare value N raises `irq` for one cycle every N+1 count clocks, and the first interrupt comes N+1 clocks after the start.
- R8: In square-wave mode (function 1), the timer level toggles on each underflow, so it has a period of 2(N+1) count clocks.
- R9: In event counter mode (function 2), the counter steps once per rising edge of `ext_evt`. `cnt_tick` is ignored, and a held high level counts only once.
- R10: In delay mode (function 3), the counter raises one interrupt when it passes zero and then clears its own `en_stat` bit.
- R11: In PWM mode (function 4), the timer level is 1 while the count is greater than the duty value, and the period is N+1 count clocks.
- R12: When split, the upper half counts in interval style with the high compare byte and drives `irq[1]`. The lower half uses the low compare byte and drives `irq[0]`. Each half is started and stopped independently.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Register address |
| wr_data | input | CNT_W/2 | Register write data |
| start_req | input | 2 | Start pulses: bit 0 lower/whole, bit 1 upper |
| stop_req | input | 2 | Stop pulses: bit 0 lower/whole, bit 1 upper |
| cnt_tick | input | 1 | Count clock enable |
| ext_evt | input | 1 | External event input |
| tmr_pin | output | 1 | Timer output pin level |
| en_stat | output | 2 | Running status per half |
| irq | output | 2 | One-cycle interrupt per half |

## Verification
Some rules are checked by the embedded assertions on every cycle. These cover the start and stop effect on the status bits, including stop priority. They also cover the upper status bit staying clear while the channel is whole, the software level holding still while output is enabled, the delay one-shot clearing its own enable when it fires, and the upper interrupt occurring only in split mode. Other behaviour can only be shown by the bench scenarios: the exact interrupt periods for given compare values, square-wave and PWM pin waveforms, edge-only event counting, the independent running of the two halves, and a channel built without split capability counting the full 16-bit value.

// File: rtl/split_timer_chan.sv
module split_timer_chan #(
  parameter int CNT_W    = 16,
  parameter bit SPLIT_OK = 1'b1,
  parameter int AW       = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [CNT_W/2-1:0] wr_data,
  input  logic [1:0]       start_req,
  input  logic [1:0]       stop_req,
  input  logic             cnt_tick,
  input  logic             ext_evt,
  output logic             tmr_pin,
  output logic [1:0]       en_stat,
  output logic [1:0]       irq
);
  localparam int HW = CNT_W / 2;
  localparam logic [2:0] F_INT = 3'd0, F_SQW = 3'd1, F_EVT = 3'd2, F_DLY = 3'd3, F_PWM = 3'd4;
  localparam logic [AW-1:0] A_OE = 0, A_LVL = 1, A_MODE = 2, A_CMPL = 3, A_CMPH = 4,
                            A_DUTL = 5, A_DUTH = 6;
  localparam logic [CNT_W-1:0] ONE   = {{(CNT_W-1){1'b0}}, 1'b1};
  localparam logic [HW-1:0]    ONE_H = {{(HW-1){1'b0}}, 1'b1};
  localparam logic [CNT_W-1:0] LO_MASK = {{HW{1'b0}}, {HW{1'b1}}};

  logic             oe_q, sw_q, tog_q, evt_q;
  logic [3:0]       mode_q;
  logic [CNT_W-1:0] cmp_q, duty_q, cnt_q;
  logic [1:0]       en_q, irq_q;

  logic             split;
  logic [2:0]       func;
  logic [CNT_W-1:0] mask, cnt_v, cmp_v, duty_v, view_n, cnt_n;
  logic [HW-1:0]    hi_n;
  logic [1:0]       en_n, irq_n;
  logic             tog_n, adv_lo, go0, go1, run0, run1, lvl;

  generate
    if (SPLIT_OK) begin : g_split
      assign split = mode_q[3];
    end else begin : g_whole
      assign split = 1'b0;
    end
  endgenerate

  assign func   = mode_q[2:0];
  assign mask   = split ? LO_MASK : '1;
  assign cnt_v  = cnt_q & mask;
  assign cmp_v  = cmp_q & mask;
  assign duty_v = duty_q & mask;
  assign adv_lo = (func == F_EVT) ? (ext_evt & ~evt_q) : cnt_tick;
  assign go0    = start_req[0] & ~stop_req[0];
  assign go1    = start_req[1] & ~stop_req[1] & split;
  assign run0   = en_q[0] & ~stop_req[0];
  assign run1   = en_q[1] & ~stop_req[1] & split;

  always_comb begin
    en_n[0] = (en_q[0] | start_req[0]) & ~stop_req[0];
    en_n[1] = split & (en_q[1] | start_req[1]) & ~stop_req[1];
    irq_n   = '0;
    tog_n   = tog_q;
    view_n  = cnt_v;
    if (go0) begin
      view_n = cmp_v;
    end else if (run0 && adv_lo) begin
      if (cnt_v == '0) begin
        irq_n[0] = 1'b1;
        if (func == F_SQW) tog_n = ~tog_q;
        if (func == F_DLY) en_n[0] = 1'b0;
        else view_n = cmp_v;
      end else begin
        view_n = cnt_v - ONE;
      end
    end
    hi_n = cnt_q[CNT_W-1:HW];
    if (go1) begin
      hi_n = cmp_q[CNT_W-1:HW];
    end else if (run1 && cnt_tick) begin
      if (cnt_q[CNT_W-1:HW] == '0) begin
        irq_n[1] = 1'b1;
        hi_n     = cmp_q[CNT_W-1:HW];
      end else begin
        hi_n = cnt_q[CNT_W-1:HW] - ONE_H;
      end
    end
    cnt_n = split ? {hi_n, view_n[HW-1:0]} : view_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      irq_q  <= '0;
      cnt_q  <= '0;
      tog_q  <= 1'b0;
      evt_q  <= 1'b0;
    end else begin
      en_q   <= en_n;
      irq_q  <= irq_n;
      cnt_q  <= cnt_n;
      tog_q  <= tog_n;
      evt_q  <= ext_evt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_q   <= 1'b0;
      sw_q   <= 1'b0;
      mode_q <= '0;
      cmp_q  <= '0;
      duty_q <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        A_OE:   oe_q <= wr_data[0];
        A_LVL:  if (!oe_q) sw_q <= wr_data[0];
        A_MODE: mode_q <= wr_data[3:0];
        A_CMPL: cmp_q[HW-1:0] <= wr_data;
        A_CMPH: cmp_q[CNT_W-1:HW] <= wr_data;
        A_DUTL: duty_q[HW-1:0] <= wr_data;
        A_DUTH: duty_q[CNT_W-1:HW] <= wr_data;
        default: ;
      endcase
    end
  end

  assign lvl     = (func == F_PWM) ? (cnt_v > duty_v) : tog_q;
  assign tmr_pin = oe_q ? lvl : sw_q;
  assign en_stat = en_q;
  assign irq     = irq_q;

  a_r1_start_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (start_req[0] && !stop_req[0]) |=> en_stat[0]);
  a_r3_stop_wins_lo: assert property (@(posedge clk) disable iff (!rst_n)
    stop_req[0] |=> !en_stat[0]);
  a_r3_stop_wins_hi: assert property (@(posedge clk) disable iff (!rst_n)
    stop_req[1] |=> !en_stat[1]);
  a_r5_whole_no_upper: assert property (@(posedge clk) disable iff (!rst_n)
    !split |=> !en_stat[1]);
  a_r6_level_locked: assert property (@(posedge clk) disable iff (!rst_n)
    oe_q |=> $stable(sw_q));
  a_r10_delay_self_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (func == F_DLY && irq_q[0] && $stable(mode_q)) |-> !en_q[0]);
  a_r12_upper_irq_split: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q[1] && $stable(mode_q)) |-> split);
endmodule

// File: tb/split_timer_chan_tb.sv
`timescale 1ns/1ps
module split_timer_chan_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [1:0] start_req = '0, stop_req = '0;
  logic cnt_tick = 1'b1, ext_evt = 1'b0;
  logic pin1, pin2;
  logic [1:0] en1, en2, irq1, irq2;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  typedef struct {
    bit chk; bit sel; bit cp;
    logic [1:0] en; logic [1:0] irq; logic pin;
    string tag;
  } exp_t;
  exp_t q[$];
  exp_t e;

  always #10 clk = ~clk;

  split_timer_chan #(.CNT_W(16), .SPLIT_OK(1'b1), .AW(3)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .start_req(start_req), .stop_req(stop_req), .cnt_tick(cnt_tick), .ext_evt(ext_evt),
    .tmr_pin(pin1), .en_stat(en1), .irq(irq1));

  split_timer_chan #(.CNT_W(16), .SPLIT_OK(1'b0), .AW(3)) u_dut_ns (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .start_req(start_req), .stop_req(stop_req), .cnt_tick(cnt_tick), .ext_evt(ext_evt),
    .tmr_pin(pin2), .en_stat(en2), .irq(irq2));

  task automatic step(bit chk, bit sel, bit cp, logic [1:0] en, logic [1:0] irq,
                      logic pin, string tag);
    exp_t x;
    x.chk = chk; x.sel = sel; x.cp = cp; x.en = en; x.irq = irq; x.pin = pin; x.tag = tag;
    q.push_back(x);
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d, bit chk, logic [1:0] en,
                    logic [1:0] irq, logic pin, string tag);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    step(chk, 1'b0, 1'b1, en, irq, pin, tag);
    wr_en = 1'b0;
  endtask

  always begin
    @(posedge clk);
    #2;
    if (q.size() > 0) begin
      logic [1:0] a_en, a_irq;
      logic a_pin;
      e = q.pop_front();
      a_en  = e.sel ? en2 : en1;
      a_irq = e.sel ? irq2 : irq1;
      a_pin = e.sel ? pin2 : pin1;
      if (e.chk) begin
        checks++;
        if (a_en !== e.en || a_irq !== e.irq || (e.cp && a_pin !== e.pin)) begin
          errors++;
          $display("FAIL %s: en=%b irq=%b pin=%b expected en=%b irq=%b pin=%b",
                   e.tag, a_en, a_irq, a_pin, e.en, e.irq, e.pin);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step(1, 0, 1, 2'b00, 2'b00, 1'b0, "R4 reset state");

    start_req = 2'b10;
    step(1, 0, 1, 2'b00, 2'b00, 1'b0, "R5 upper start ignored while whole");
    start_req = 2'b00;

    // interval, compare 3
    wr(3'd3, 8'd3, 0, 2'b00, 2'b00, 1'b0, "");
    wr(3'd0, 8'd1, 0, 2'b00, 2'b00, 1'b0, "");
    start_req = 2'b01;
    step(1, 0, 1, 2'b01, 2'b00, 1'b0, "R1 start sets status");
    start_req = 2'b00;
    for (int i = 1; i <= 12; i++)
      step(1, 0, 1, 2'b01, (i % 4 == 0) ? 2'b01 : 2'b00, 1'b0, "R7 interval period");
    stop_req = 2'b01;
    step(1, 0, 1, 2'b00, 2'b00, 1'b0, "R2 stop clears status");
    start_req = 2'b01;
    step(1, 0, 1, 2'b00, 2'b00, 1'b0, "R3 stop wins while idle");
    start_req = 2'b00; stop_req = 2'b00;
    step(1, 0, 1, 2'b00, 2'b00, 1'b0, "R2 stays stopped");

    // square wave, compare 2
    wr(3'd2, 8'd1, 0, 2'b00, 2'b00, 1'b0, "");
    wr(3'd3, 8'd2, 0, 2'b00, 2'b00, 1'b0, "");
    start_req = 2'b01;
    step(1, 0, 1, 2'b01, 2'b00, 1'b0, "R8 start");
    start_req = 2'b00;
    for (int i = 1; i <= 9; i++)
      step(1, 0, 1, 2'b01, (i % 3 == 0) ? 2'b01 : 2'b00, logic'((i / 3) % 2),
           "R8 square wave level");
    stop_req = 2'b01;
    step(1, 0, 1, 2'b00, 2'b00, 1'b1, "R2 stop freezes level");
    stop_req = 2'b00;

    // output lock
    wr(3'd1, 8'd1, 1, 2'b00, 2'b00, 1'b1, "R6 pin follows timer while enabled");
    wr(3'd0, 8'd0, 1, 2'b00, 2'b00, 1'b0, "R6 locked write was discarded");
    wr(3'd1, 8'd1, 1, 2'b00, 2'b00, 1'b1, "R6 software level drives pin");
    wr(3'd1, 8'd0, 1, 2'b00, 2'b00, 1'b0, "R6 software level low");
    wr(3'd0, 8'd1, 1, 2'b00, 2'b00, 1'b1, "R6 timer level restored");

    // stop wins while running
    start_req = 2'b01;
    step(1, 0, 1, 2'b01, 2'b00, 1'b1, "R1 restart");
    stop_req = 2'b01;
    step(1, 0, 1, 2'b00, 2'b00, 1'b1, "R3 stop wins while running");
    start_req = 2'b00; stop_req = 2'b00;

    // split: low compare 2, high compare 4
    wr(3'd2, 8'd8, 0, 2'b00, 2'b00, 1'b0, "");
    wr(3'd3, 8'd2, 0, 2'b00, 2'b00, 1'b0, "");
    wr(3'd4, 8'd4, 0, 2'b00, 2'b00, 1'b0, "");
    start_req = 2'b11;
    step(1, 0, 1, 2'b11, 2'b00, 1'b1, "R12 both halves start");
    start_req = 2'b00;
    for (int i = 1; i <= 10; i++)
      step(1, 0, 1, 2'b11, {(i % 5 == 0), (i % 3 == 0)}, 1'b1, "R12 independent periods");
    stop_req = 2'b10;
    step(1, 0, 1, 2'b01, 2'b00, 1'b1, "R1 zero stop bit leaves lower running");
    stop_req = 2'b00;
    for (int i = 12; i <= 15; i++)
      step(1, 0, 1, 2'b01, {1'b0, (i % 3 == 0)}, 1'b1, "R12 lower runs upper stopped");
    start_req = 2'b10;
    step(1, 0, 1, 2'b11, 2'b00, 1'b1, "R12 upper restarted alone");
    start_req = 2'b00; stop_req = 2'b11;
    step(1, 0, 1, 2'b00, 2'b00, 1'b1, "R2 both halves stopped");
    stop_req = 2'b00;

    // event counter, compare 1, tick left high
    wr(3'd2, 8'd2, 0, 2'b00, 2'b00, 1'b0, "");
    wr(3'd4, 8'd0, 0, 2'b00, 2'b00, 1'b0, "");
    wr(3'd3, 8'd1, 0, 2'b00, 2'b00, 1'b0, "");
    start_req = 2'b01;
    step(1, 0, 1, 2'b01, 2'b00, 1'b1, "R9 start");
    start_req = 2'b00; ext_evt = 1'b1;
    step(1, 0, 1, 2'b01, 2'b00, 1'b1, "R9 first edge counts");
    step(1, 0, 1, 2'b01, 2'b00, 1'b1, "R9 held level no count");
    ext_evt = 1'b0;
    step(1, 0, 1, 2'b01, 2'b00, 1'b1, "R9 tick ignored");
    ext_evt = 1'b1;
    step(1, 0, 1, 2'b01, 2'b01, 1'b1, "R9 second edge underflows");
    ext_evt = 1'b0; stop_req = 2'b01;
    step(1, 0, 1, 2'b00, 2'b00, 1'b1, "R2 stop event counter");
    stop_req = 2'b00;

    // delay one-shot, compare 2
    wr(3'd2, 8'd3, 0, 2'b00, 2'b00, 1'b0, "");
    wr(3'd3, 8'd2, 0, 2'b00, 2'b00, 1'b0, "");
    start_req = 2'b01;
    step(1, 0, 1, 2'b01, 2'b00, 1'b1, "R10 start");
    start_req = 2'b00;
    step(1, 0, 1, 2'b01, 2'b00, 1'b1, "R10 counting");
    step(1, 0, 1, 2'b01, 2'b00, 1'b1, "R10 counting");
    step(1, 0, 1, 2'b00, 2'b01, 1'b1, "R10 fires and stops");
    step(1, 0, 1, 2'b00, 2'b00, 1'b1, "R10 single shot");
    step(1, 0, 1, 2'b00, 2'b00, 1'b1, "R10 single shot");

    // PWM, compare 3, duty 1
    wr(3'd2, 8'd4, 0, 2'b00, 2'b00, 1'b0, "");
    wr(3'd3, 8'd3, 0, 2'b00, 2'b00, 1'b0, "");
    wr(3'd5, 8'd1, 0, 2'b00, 2'b00, 1'b0, "");
    start_req = 2'b01;
    step(1, 0, 1, 2'b01, 2'b00, 1'b1, "R11 start high");
    start_req = 2'b00;
    for (int i = 1; i <= 8; i++)
      step(1, 0, 1, 2'b01, (i % 4 == 0) ? 2'b01 : 2'b00, logic'((3 - (i % 4)) > 1),
           "R11 pwm level");
    stop_req = 2'b01;
    step(0, 0, 0, 2'b00, 2'b00, 1'b0, "");
    stop_req = 2'b00;

    // channel without split capability: request split, compare 0x0101
    wr(3'd2, 8'd8, 0, 2'b00, 2'b00, 1'b0, "");
    wr(3'd3, 8'd1, 0, 2'b00, 2'b00, 1'b0, "");
    wr(3'd4, 8'd1, 0, 2'b00, 2'b00, 1'b0, "");
    start_req = 2'b11;
    step(1, 1, 0, 2'b01, 2'b00, 1'b0, "R5 split request refused");
    start_req = 2'b00;
    for (int i = 1; i <= 258; i++)
      step(1, 1, 0, 2'b01, (i == 258) ? 2'b01 : 2'b00, 1'b0, "R5 whole 16-bit period");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule